// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Master

This block runs one SPI transfer over a small byte buffer when a bridge controller asks for it. The controller fills the buffer through a plain write port, loads a 5-bit configuration word, and then pulses a start strobe with a byte count and a slave index. The engine shifts each buffered byte out on MOSI, samples MISO at the same time, and writes the received byte back into the same location. The controller can therefore read a peripheral by sending filler bytes such as FFh: when the transfer ends, the replies sit where the filler was.

The configuration word gives the idle level of SCLK, the clock phase, the bit order and a 2-bit rate code. The rate code picks one of four half-period lengths that are power-of-two multiples of a base count. The chosen active-low select is pulled low half a bit period before the first clock edge and released half a bit period after the last one. A one-cycle done pulse marks the release. Message decoding belongs to the controller and is not part of this block.

Top module: `spim_buffered_master`

## Requirements
- R1: Out of reset, all selects are high, SCLK and MOSI are low, done is low and the configuration word is zero.
- R2: Configuration word fields: bit 0 set means LSB-first, bit 1 is the SCLK idle level, bit 2 is the clock phase, bits 4:3 are the rate code. The half bit period is HALF_BASE shifted left by the rate code, which gives 2, 4, 8 or 16 clocks with the default base. The word is captured when a transfer starts.
- R3: A transfer of N bytes sends buffer locations 0 to N-1 in address order. The byte received during byte i replaces location i.
- R4: With phase 0, MOSI is valid before the leading SCLK edge, the leading edge samples MISO and the trailing edge changes MOSI. With phase 1, the leading edge changes MOSI and the trailing edge samples MISO.
- R5: Bits of each byte go out, and come in, MSB-first or LSB-first as bit 0 of the configuration word selects.
- R6: While no transfer runs, SCLK rests at the configured idle level.
- R7: Only the select indexed by start_sel goes low. It stays low without a break for the whole transfer, and the other selects stay high.
- R8: The first SCLK edge comes exactly one half period after the select falls. Edges follow one another every half period, with no gap between bytes. The select rises one half period after the last edge, and there are 16 edges per byte.
- R9: done is high for exactly one cycle: the first cycle in which the select is high again.
- R10: A start with a count of zero or above DEPTH is ignored. While a transfer runs, start, buffer writes and configuration writes do not affect it, and the engine's write-back owns the buffer.
- R11: buf_rdata shows the location addressed by buf_raddr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration word |
| cfg_wdata | input | 5 | Configuration word (order, idle level, phase, rate) |
| buf_we | input | 1 | Buffer write strobe |
| buf_waddr | input | 4 | Buffer write address |
| buf_wdata | input | 8 | Buffer write data |
| buf_raddr | input | 4 | Buffer read address |
| buf_rdata | output | 8 | Buffer read data, one clock latency |
| start | input | 1 | Begin a transfer |
| start_len | input | 5 | Number of bytes to transfer |
| start_sel | input | 2 | Index of the select to assert |
| done | output | 1 | One-cycle pulse after the select releases |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 4 | Active-low slave selects |

## Verification
The engine's write-back of a received byte can land in the same cycle as a controller write to the buffer, a new start, or a new configuration word. The collision is provoked by holding buf_we on location 0, holding start with another select, and writing a slower rate code on every cycle of a running transfer. The result is judged at the ports afterwards: the buffer must hold the peripheral's replies, the edge spacing must keep the rate captured at the start, exactly one select must have moved, and exactly one done pulse must appear.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Configuration word, MSB to LSB: rate[1:0], cpha, cpol, lsb_first
  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
  } spim_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_FIN
  } spim_state_e;

  // Wire position of transfer bit n inside a byte
  function automatic logic [2:0] bit_pos(input logic lsb, input logic [2:0] n);
    return lsb ? n : (3'd7 - n);
  endfunction

endpackage

// File: rtl/spim_buffer.sv
module spim_buffer #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [7:0]    host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [7:0]    host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata
);

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_n;

  // Storage: engine write-back takes priority over the host port
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (eng_we && (eng_waddr == AW'(i))) begin
        mem[i] <= eng_wdata;
      end else if (host_we && (host_waddr == AW'(i))) begin
        mem[i] <= host_wdata;
      end
    end
  end

  assign rdata_n   = mem[host_raddr];
  assign eng_rdata = mem[eng_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= rdata_n;
  end

endmodule

// File: rtl/spim_half_timer.sv
module spim_half_timer #(
  parameter int HALF_BASE = 2,
  parameter int TW        = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] rate,
  output logic       expired
);

  logic [TW-1:0] cnt_q, cnt_n, reload;

  assign reload  = (TW'(HALF_BASE) << rate) - TW'(1);
  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load)          cnt_n = reload;
    else if (!expired) cnt_n = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int LENW  = 5,
  parameter int NSEL  = 4,
  parameter int SELW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  spim_cfg_t       cfg,
  input  logic            start,
  input  logic [LENW-1:0] start_len,
  input  logic [SELW-1:0] start_sel,
  input  logic            tick,
  output logic            tmr_load,
  output logic [1:0]      tmr_rate,
  input  logic [7:0]      rd_data,
  output logic [AW-1:0]   rd_addr,
  output logic            wb_we,
  output logic [AW-1:0]   wb_addr,
  output logic [7:0]      wb_data,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic [NSEL-1:0] ss_n,
  output logic            done,
  output logic            busy
);

  spim_state_e     state_q, state_n;
  spim_cfg_t       act_q, act_n;
  logic [AW-1:0]   idx_q, idx_n, last_q, last_n;
  logic [3:0]      edge_q, edge_n;
  logic [7:0]      rx_q, rx_n, tx_q, tx_n;
  logic            sclk_q, sclk_n, mosi_q, mosi_n;
  logic [NSEL-1:0] ss_q, ss_n_n;
  logic            go, leading, sampling, last_edge;
  logic [2:0]      bitn;

  assign go = (state_q == ST_IDLE) && start && (start_len != '0) &&
              (start_len <= LENW'(DEPTH));
  assign bitn      = edge_q[3:1];
  assign leading   = ~edge_q[0];
  assign sampling  = leading ^ act_q.cpha;
  assign last_edge = (edge_q == 4'd15);

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign ss_n     = ss_q;
  assign wb_addr  = idx_q;
  assign wb_data  = rx_n;
  assign tmr_rate = (state_q == ST_IDLE) ? cfg.rate : act_q.rate;
  assign rd_addr  = ((state_q == ST_SHIFT) && (idx_q != last_q)) ? idx_q + AW'(1) : idx_q;

  always_comb begin
    state_n  = state_q;
    act_n    = act_q;
    idx_n    = idx_q;
    last_n   = last_q;
    edge_n   = edge_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    sclk_n   = sclk_q;
    mosi_n   = mosi_q;
    ss_n_n   = ss_q;
    tmr_load = 1'b0;
    wb_we    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        sclk_n = cfg.cpol;
        if (go) begin
          act_n    = cfg;
          idx_n    = '0;
          last_n   = AW'(start_len - LENW'(1));
          tx_n     = rd_data;
          rx_n     = '0;
          edge_n   = '0;
          mosi_n   = rd_data[bit_pos(cfg.lsb_first, 3'd0)];
          ss_n_n   = ~(NSEL'(1) << start_sel);
          tmr_load = 1'b1;
          state_n  = ST_LEAD;
        end
      end
      ST_LEAD, ST_SHIFT: begin
        if (tick) begin
          sclk_n   = ~sclk_q;
          tmr_load = 1'b1;
          edge_n   = edge_q + 4'd1;
          state_n  = ST_SHIFT;
          if (sampling) begin
            rx_n[bit_pos(act_q.lsb_first, bitn)] = miso;
          end else if (leading) begin
            mosi_n = tx_q[bit_pos(act_q.lsb_first, bitn)];
          end else if (!last_edge) begin
            mosi_n = tx_q[bit_pos(act_q.lsb_first, bitn + 3'd1)];
          end
          if (last_edge) begin
            wb_we = 1'b1;
            if (idx_q == last_q) begin
              state_n = ST_TRAIL;
            end else begin
              idx_n  = idx_q + AW'(1);
              tx_n   = rd_data;
              edge_n = '0;
              if (!act_q.cpha) mosi_n = rd_data[bit_pos(act_q.lsb_first, 3'd0)];
            end
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          ss_n_n  = '1;
          state_n = ST_FIN;
        end
      end
      ST_FIN: begin
        idx_n   = '0;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      edge_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      ss_q    <= '1;
    end else begin
      state_q <= state_n;
      act_q   <= act_n;
      idx_q   <= idx_n;
      last_q  <= last_n;
      edge_q  <= edge_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      sclk_q  <= sclk_n;
      mosi_q  <= mosi_n;
      ss_q    <= ss_n_n;
    end
  end

endmodule

// File: rtl/spim_buffered_master.sv
module spim_buffered_master
  import spim_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NSEL      = 4,
  parameter int HALF_BASE = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int LENW     = $clog2(DEPTH + 1),
  localparam int SELW     = $clog2(NSEL),
  localparam int CFGW     = $bits(spim_cfg_t),
  localparam int TW       = $clog2(HALF_BASE * 8) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            buf_we,
  input  logic [AW-1:0]   buf_waddr,
  input  logic [7:0]      buf_wdata,
  input  logic [AW-1:0]   buf_raddr,
  output logic [7:0]      buf_rdata,
  input  logic            start,
  input  logic [LENW-1:0] start_len,
  input  logic [SELW-1:0] start_sel,
  output logic            done,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [NSEL-1:0] spi_ss_n
);

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  spim_cfg_t     cfg_q, cfg_n;
  logic          busy, tick, tmr_load, wb_we;
  logic [1:0]    tmr_rate;
  logic [AW-1:0] rd_addr, wb_addr;
  logic [7:0]    rd_data, wb_data;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_we) cfg_n = spim_cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cfg_q <= '0;
    else             cfg_q <= cfg_n;
  end

  spim_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .host_we    (buf_we & ~busy),
    .host_waddr (buf_waddr),
    .host_wdata (buf_wdata),
    .host_raddr (buf_raddr),
    .host_rdata (buf_rdata),
    .eng_we     (wb_we),
    .eng_waddr  (wb_addr),
    .eng_wdata  (wb_data),
    .eng_raddr  (rd_addr),
    .eng_rdata  (rd_data)
  );

  spim_half_timer #(.HALF_BASE(HALF_BASE), .TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (tmr_load),
    .rate    (tmr_rate),
    .expired (tick)
  );

  spim_engine #(
    .DEPTH(DEPTH), .AW(AW), .LENW(LENW), .NSEL(NSEL), .SELW(SELW)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg       (cfg_q),
    .start     (start),
    .start_len (start_len),
    .start_sel (start_sel),
    .tick      (tick),
    .tmr_load  (tmr_load),
    .tmr_rate  (tmr_rate),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wb_we     (wb_we),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .ss_n      (spi_ss_n),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: rtl/spim_buffered_master_chk.sv
module spim_buffered_master_chk #(
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            spi_sclk,
  input logic [NSEL-1:0] spi_ss_n,
  input logic            done
);

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_ss_n) <= 1);

  a_r7_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&spi_ss_n) && !$past(&spi_ss_n)) |-> $stable(spi_ss_n));

  a_r8_quiet_on_assert: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&spi_ss_n) |-> $stable(spi_sclk));

  a_r8_quiet_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&spi_ss_n) |-> $stable(spi_sclk));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(&spi_ss_n));

  a_r9_release_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&spi_ss_n) |-> done);

endmodule

bind spim_buffered_master spim_buffered_master_chk #(.NSEL(NSEL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_sclk (spi_sclk),
  .spi_ss_n (spi_ss_n),
  .done     (done)
);

// File: tb/spim_buffered_master_test.sv
module spim_buffered_master_test;

  logic       clk, rst_n;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic       buf_we;
  logic [3:0] buf_waddr, buf_raddr;
  logic [7:0] buf_wdata, buf_rdata;
  logic       start;
  logic [4:0] start_len;
  logic [1:0] start_sel;
  logic       done, spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_ss_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  spim_buffered_master uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- peripheral model ----------------
  logic [7:0] tx_b [16];
  logic [7:0] rep_b [16];
  logic [7:0] cap_b [16];
  bit s_cpol, s_cpha, s_lsb, lead;
  int s_len, gtx, grx;
  bit prev_act = 0, prev_sck = 0;
  wire sel_act = ~&spi_ss_n;

  function automatic logic rep_bit(input int g);
    int n;
    if (g >= 8 * s_len) return 1'b1;
    n = s_lsb ? (g % 8) : (7 - (g % 8));
    return rep_b[g / 8][n];
  endfunction

  always @(spi_sclk or sel_act) begin
    if (sel_act && !prev_act) begin
      gtx = 0; grx = 0;
      if (!s_cpha) begin spi_miso = rep_bit(0); gtx = 1; end
    end else if (sel_act && (spi_sclk != prev_sck)) begin
      lead = (spi_sclk != s_cpol);
      if (lead != s_cpha) begin
        if (grx < 8 * s_len)
          cap_b[grx / 8][s_lsb ? (grx % 8) : (7 - (grx % 8))] = spi_mosi;
        grx++;
      end else begin
        spi_miso = rep_bit(gtx);
        gtx++;
      end
    end
    prev_act = sel_act;
    prev_sck = spi_sclk;
  end

  // ---------------- port monitor (negedge) ----------------
  int cyc = 0, t_fall, t_first, t_last, t_rise, n_edges, gmin, gmax;
  int ss_falls, bad_sel, done_cnt, done_ok, exp_sel;
  bit m_prev_all = 1, m_prev_sck = 0;

  task automatic mon_clear();
    t_fall = -1; t_first = -1; t_last = -1; t_rise = -1; n_edges = 0;
    gmin = 1000000; gmax = 0; ss_falls = 0; bad_sel = 0; done_cnt = 0; done_ok = 0;
  endtask

  always @(negedge clk) begin
    bit all;
    cyc++;
    all = &spi_ss_n;
    if (m_prev_all && !all) begin ss_falls++; t_fall = cyc; end
    if (!m_prev_all && all) t_rise = cyc;
    if (!all && (spi_sclk != m_prev_sck)) begin
      if (n_edges == 0) t_first = cyc;
      else begin
        if (cyc - t_last < gmin) gmin = cyc - t_last;
        if (cyc - t_last > gmax) gmax = cyc - t_last;
      end
      t_last = cyc;
      n_edges++;
    end
    if (!all && (spi_ss_n != ~(4'b1 << exp_sel))) bad_sel++;
    if (done) begin
      done_cnt++;
      if (all && !m_prev_all) done_ok++;
    end
    m_prev_all = all;
    m_prev_sck = spi_sclk;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [4:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_buf(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_waddr = 4'(a); buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic read_buf(input int a, output logic [7:0] d);
    @(negedge clk); buf_raddr = 4'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One transfer: program, run, then judge at the ports
  task automatic xfer(input logic [4:0] w, input int sel, input int len,
                      input bit stress, input string tag);
    int h, waitc;
    logic [7:0] v;
    h = 2 << w[4:3];
    s_lsb = w[0]; s_cpol = w[1]; s_cpha = w[2]; s_len = len;
    write_cfg(w);
    repeat (2) @(negedge clk);
    chk(spi_sclk == w[1], {tag, " R6 idle level before"}, int'(spi_sclk), int'(w[1]));
    for (int i = 0; i < len; i++) begin
      write_buf(i, tx_b[i]);
      cap_b[i] = 8'h00;
    end
    mon_clear();
    exp_sel = sel;
    @(negedge clk); start = 1'b1; start_len = 5'(len); start_sel = 2'(sel);
    @(negedge clk);
    if (!stress) start = 1'b0;
    waitc = 0;
    while (!done && waitc < 20000) begin
      if (stress) begin
        buf_we = 1'b1; buf_waddr = 4'd0; buf_wdata = 8'h5A;
        start = 1'b1; start_len = 5'd1; start_sel = 2'((sel + 1) % 4);
        cfg_we = 1'b1; cfg_wdata = {2'd3, w[2:0]};
      end
      @(negedge clk);
      waitc++;
    end
    buf_we = 1'b0; start = 1'b0; cfg_we = 1'b0;
    chk(done == 1'b1, {tag, " R9 done seen"}, int'(done), 1);
    repeat (3) @(negedge clk);
    chk(ss_falls == 1 && bad_sel == 0, {tag, " R7 single select framing"}, bad_sel + ss_falls, 1);
    chk(t_first - t_fall == h, {tag, " R8 select lead"}, t_first - t_fall, h);
    chk(t_rise - t_last == h, {tag, " R8 select trail"}, t_rise - t_last, h);
    chk(gmin == h && gmax == h, {tag, " R2 R8 edge spacing"}, gmax, h);
    chk(n_edges == 16 * len, {tag, " R8 edge count"}, n_edges, 16 * len);
    chk(done_cnt == 1 && done_ok == 1, {tag, " R9 done once at release"}, done_cnt, 1);
    chk(spi_sclk == w[1], {tag, " R6 idle level after"}, int'(spi_sclk), int'(w[1]));
    for (int i = 0; i < len; i++) begin
      chk(cap_b[i] == tx_b[i], {tag, " R3 R4 R5 byte sent"}, int'(cap_b[i]), int'(tx_b[i]));
      read_buf(i, v);
      chk(v == rep_b[i], {tag, " R3 R11 reply written back"}, int'(v), int'(rep_b[i]));
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(spi_ss_n == 4'hF, "R1 selects high", int'(spi_ss_n), 15);
    chk(spi_sclk == 1'b0, "R1 sclk low", int'(spi_sclk), 0);
    chk(spi_mosi == 1'b0, "R1 mosi low", int'(spi_mosi), 0);
    chk(done == 1'b0, "R1 done low", int'(done), 0);
  endtask

  task automatic t_mode0_msb();
    tx_b[0] = 8'hA5; tx_b[1] = 8'h3C; tx_b[2] = 8'h01;
    rep_b[0] = 8'h96; rep_b[1] = 8'hF0; rep_b[2] = 8'h7E;
    xfer(5'b00_0_0_0, 0, 3, 0, "mode0");
  endtask

  task automatic t_mode3_lsb();
    tx_b[0] = 8'h81; tx_b[1] = 8'h4E;
    rep_b[0] = 8'h0F; rep_b[1] = 8'hC3;
    xfer(5'b01_1_1_1, 2, 2, 0, "mode3lsb");
  endtask

  task automatic t_mode1_slow();
    tx_b[0] = 8'h6D; rep_b[0] = 8'hB2;
    xfer(5'b11_1_0_0, 3, 1, 0, "mode1slow");
  endtask

  task automatic t_filler_read();
    for (int i = 0; i < 4; i++) begin
      tx_b[i] = 8'hFF;
      rep_b[i] = 8'(8'h12 + 8'(i) * 8'h22);
    end
    xfer(5'b10_0_1_1, 1, 4, 0, "filler");
  endtask

  task automatic t_ignored_start();
    mon_clear();
    exp_sel = 0;
    @(negedge clk); start = 1'b1; start_len = 5'd0; start_sel = 2'd0;
    @(negedge clk); start_len = 5'd17;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    chk(ss_falls == 0 && spi_ss_n == 4'hF, "R10 bad length ignored", ss_falls, 0);
    chk(n_edges == 0 && done_cnt == 0, "R10 no clock or done", n_edges + done_cnt, 0);
  endtask

  task automatic t_collision();
    tx_b[0] = 8'hC6; tx_b[1] = 8'h19;
    rep_b[0] = 8'h2B; rep_b[1] = 8'hE4;
    xfer(5'b00_0_0_0, 1, 2, 1, "collide R10");
  endtask

  task automatic t_full_depth();
    for (int i = 0; i < 16; i++) begin
      tx_b[i] = 8'(i * 17 + 3);
      rep_b[i] = ~8'(i * 29);
    end
    xfer(5'b00_1_1_0, 0, 16, 0, "fulldepth");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; buf_we = 1'b0; buf_waddr = '0;
    buf_wdata = '0; buf_raddr = '0; start = 1'b0; start_len = '0; start_sel = '0;
    spi_miso = 1'b0; exp_sel = 0;
    mon_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode0_msb();
    t_mode3_lsb();
    t_mode1_slow();
    t_filler_read();
    t_ignored_start();
    t_collision();
    t_full_depth();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
  end

endmodule